// File: doc/BRIEF.md
# Snapshot Free-Running Counter

This block keeps a 64-bit counter that advances by one on every system clock and lets software read it as two 32-bit words without tearing. A write to the control register with the capture request set copies the full counter into a pair of 32-bit holding registers on a single clock edge. Software then reads the low and high words at leisure, and both words come from the same instant.

A second request bit zeroes both holding registers. Neither request bit is stored: each acts on the edge of the write, so the control register always reads back as zero. Software may also load either holding word directly. Access is through a simple register port with separate write and read strobes. Read data is registered and appears on the cycle after the read strobe.

Top module: `snapcnt_top`

## Requirements
- R1: The counter rises by exactly one on every clock edge that is not in reset, and it wraps from 2^64-1 to 0.
- R2: After a synchronous reset the counter, both holding words and the read data are all zero.
- R3: A write to offset 0x00 with bit 1 set and bit 0 clear loads the counter value present in the write cycle into the holding words. Counter bits [31:0] go to the word at offset 0x04 and bits [63:32] go to the word at offset 0x08.
- R4: A write to offset 0x00 with bit 0 set makes both holding words zero.
- R5: When one control write sets both bit 0 and bit 1, the capture is applied first and the clear second, so both holding words end up zero.
- R6: A read of offset 0x00 always returns zero, including after a write that set either request bit.
- R7: A write to offset 0x04 or 0x08 loads the written data into the low or high holding word.
- R8: A holding word keeps its value across any cycle without a write that reaches it. This includes a control write with bits 1:0 both zero.
- R9: Read data is updated one cycle after the read strobe. Reads of any other offset return zero, and writes to such offsets change nothing.
- R10: A read and a write to the same holding word in one cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |

## Verification
Two pairs of functions can land on the same edge. In the first pair, one control write carries both the capture and the clear request. The bench provokes this with directed writes of 0x3 to the control register, and also with random control data. It then expects both holding words to read zero. In the second pair, a read and a direct write hit the same holding word in one cycle. The bench drives both strobes together and requires the read to return the value the bench model held before that write.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int CTRL_OFS  = 0;
  localparam int WORD0_OFS = 4;
  localparam int WORD_STEP = 4;
  localparam int BIT_CLEAR = 0;
  localparam int BIT_LATCH = 1;

  typedef struct packed {
    logic latch;
    logic clear;
  } req_t;
endpackage

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/snapcnt_regif.sv
module snapcnt_regif
  import snapcnt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NWORD  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NWORD*DATA_W-1:0] hold_i,
  output req_t                    req_o,
  output logic [NWORD-1:0]        word_we_o,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic              ctrl_hit;
  logic [NWORD-1:0]  word_hit;
  logic [DATA_W-1:0] rd_next;

  assign ctrl_hit     = wr_en && (addr == CTRL_A);
  assign req_o.clear  = ctrl_hit && wdata[BIT_CLEAR];
  assign req_o.latch  = ctrl_hit && wdata[BIT_LATCH];

  for (genvar k = 0; k < NWORD; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(WORD0_OFS + WORD_STEP * k);
    assign word_hit[k]  = (addr == WA);
    assign word_we_o[k] = wr_en && word_hit[k];
  end

  // Control reads as zero: request bits are never stored.
  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NWORD; k++) begin
      if (word_hit[k]) rd_next = hold_i[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_next;
  end
endmodule

// File: rtl/snapcnt_hold.sv
module snapcnt_hold
  import snapcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWORD  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWORD*DATA_W-1:0] count_i,
  input  req_t                    req_i,
  input  logic [NWORD-1:0]        word_we_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [NWORD*DATA_W-1:0] hold_o
);
  for (genvar k = 0; k < NWORD; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)               hold_o[k*DATA_W +: DATA_W] <= '0;
      else if (req_i.clear)  hold_o[k*DATA_W +: DATA_W] <= '0;
      else if (req_i.latch)  hold_o[k*DATA_W +: DATA_W] <= count_i[k*DATA_W +: DATA_W];
      else if (word_we_i[k]) hold_o[k*DATA_W +: DATA_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
  import snapcnt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NWORD = CNT_W / DATA_W;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] hold_q;
  req_t             req;
  logic [NWORD-1:0] word_we;

  snapcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .count_o(count_q)
  );

  snapcnt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORD(NWORD)) u_regif (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .hold_i(hold_q),
    .req_o(req), .word_we_o(word_we), .rdata_o(bus_rdata)
  );

  snapcnt_hold #(.DATA_W(DATA_W), .NWORD(NWORD)) u_hold (
    .clk(clk), .rst(rst), .count_i(count_q), .req_i(req),
    .word_we_i(word_we), .wdata_i(bus_wdata), .hold_o(hold_q)
  );
endmodule

// File: rtl/snapcnt_chk.sv
module snapcnt_chk #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  hold
);
  localparam int NWORD = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(4 + 4 * NWORD);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count == CNT_W'($past(count) + 1'b1)); // R1
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wdata[1] && !wdata[0]) |=> hold == $past(count)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wdata[0]) |=> hold == '0); // R4
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL) |=> rdata == '0); // R6
  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_LOW) |=> hold[DATA_W-1:0] == $past(wdata)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(hold)); // R8
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= A_END) |=> rdata == '0); // R9
  AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_LOW) |=> rdata == $past(hold[DATA_W-1:0])); // R10
endmodule

bind snapcnt_top snapcnt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
  .wdata(bus_wdata), .rdata(bus_rdata), .count(count_q), .hold(hold_q)
);

// File: tb/snapcnt_top_tb.sv
module snapcnt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [63:0] ref_cnt;
  logic [31:0] ref_lo, ref_hi;

  always #10 clk = ~clk;

  always @(posedge clk) ref_cnt <= rst ? 64'd0 : ref_cnt + 64'd1;

  snapcnt_top dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  function automatic logic [31:0] model_read(logic [3:0] a);
    if (a == 4'h4) return ref_lo;
    if (a == 4'h8) return ref_hi;
    return 32'd0;
  endfunction

  task automatic model_write(logic [3:0] a, logic [31:0] d);
    if (a == 4'h0) begin
      if (d[0]) begin ref_lo = 0; ref_hi = 0; end
      else if (d[1]) begin ref_lo = ref_cnt[31:0]; ref_hi = ref_cnt[63:32]; end
    end else if (a == 4'h4) ref_lo = d;
    else if (a == 4'h8) ref_hi = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [3:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic rw_same(logic [3:0] a, logic [31:0] d, string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    exp = model_read(a);
    model_write(a, d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ref_lo = 0; ref_hi = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 rdata after reset", rdata, 32'd0);
    rst = 1'b0;
    do_read(4'h4, "R2 low after reset");
    do_read(4'h8, "R2 high after reset");
    do_read(4'h0, "R2 ctrl after reset");
    // capture, then read back both words
    do_write(4'h0, 32'h2);
    do_read(4'h4, "R1 R3 latched low");
    do_read(4'h8, "R3 latched high");
    do_read(4'h0, "R6 ctrl after latch");
    repeat (7) @(negedge clk);
    do_write(4'h0, 32'h2);
    do_read(4'h4, "R1 R3 second capture low");
    do_write(4'h8, 32'hDEAD_BEEF);
    do_write(4'h4, 32'h1234_5678);
    do_read(4'h8, "R7 direct high");
    do_read(4'h4, "R7 direct low");
    do_write(4'h0, 32'h0);
    do_read(4'h4, "R8 idle ctrl write low");
    do_read(4'h8, "R8 idle ctrl write high");
    do_write(4'h0, 32'h1);
    do_read(4'h8, "R4 clear high");
    do_write(4'h8, 32'hFFFF_0001);
    do_write(4'h0, 32'h3);
    do_read(4'h4, "R5 latch and clear low");
    do_read(4'h8, "R5 latch and clear high");
    do_read(4'h0, "R6 ctrl after both");
    do_write(4'hC, 32'hAAAA_5555);
    do_read(4'hC, "R9 unmapped read");
    do_read(4'h4, "R9 unmapped write ignored");
    do_write(4'h4, 32'h0BAD_F00D);
    rw_same(4'h4, 32'h1111_2222, "R10 read with write low");
    rw_same(4'h8, 32'h3333_4444, "R10 read with write high");
    do_read(4'h4, "R10 write landed");
    for (int i = 0; i < 300; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      int op;
      op = $urandom_range(0, 5);
      a  = 4'($urandom_range(0, 15));
      d  = $urandom();
      case (op)
        0: do_write(4'h0, {30'($urandom()), 2'($urandom_range(0, 3))});
        1: do_write(4'h4, d);
        2: do_write(4'h8, d);
        3: do_write(a, d);
        4: rw_same(a, d, "R10 random same-cycle");
        default: do_read(a, "R3 R7 R9 random read");
      endcase
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    finish_run();
  end
endmodule